// File: doc/BRIEF.md
# FIFO Service Interrupt Controller

This block raises service interrupts for a data-processing engine that consumes 32-bit words from an input FIFO and produces 32-bit words into an output FIFO. Both FIFOs are part of the block. The host fills the input FIFO, the engine pops from it, the engine pushes results into the output FIFO, and the host drains that FIFO. Every FIFO edge is a valid/ready stream. A word moves only on a clock edge where both valid and ready are high. A producer may hold valid high for as long as it likes while ready is low, and nothing is lost or duplicated. A consumer's ready has no effect while valid is low.

Two request sources come from the fill levels. The input source asks the host for more data while the input FIFO holds fewer than four words, and only while the engine is enabled. The output source asks the host to drain results while any word sits in the output FIFO, whatever the engine enable. A small register interface holds a per-source enable mask and shows the raw and masked source states. One registered interrupt line is the OR of the masked sources.

Top module: `svc_irq_ctrl`

## Requirements
- R1: After reset the mask register reads 0, the interrupt output is low, and both FIFOs are empty (`in_ready`=1, `eng_rd_valid`=0, `out_valid`=0).
- R2: Raw status bit 1 (output source) is 1 exactly when the output FIFO holds one or more words, regardless of `engine_en`.
- R3: Raw status bit 0 (input source) is 1 exactly when `engine_en` is 1 and the input FIFO holds 0 to 3 words. With 4 or more words, or with `engine_en` low, it reads 0.
- R4: Masked status equals raw status AND the mask. Mask bit 0 enables the input source and mask bit 1 enables the output source. A bit set to 1 enables.
- R5: `irq` on a given cycle equals the OR of the masked status bits of the previous cycle. It therefore follows a FIFO level change or a mask write one clock later.
- R6: The register byte offsets are 0x0 (mask, read/write bits [1:0]), 0x4 (raw, read-only) and 0x8 (masked, read-only). Writes to 0x4, 0x8 or any other offset change nothing. Unused bits and unmapped offsets read 0.
- R7: Each FIFO holds 8 words. Its ready is low when it is full, and a word offered then is not stored. Its read-side valid is low when it is empty, and a ready offered then removes nothing.
- R8: Each FIFO returns its words in the order they were accepted, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| engine_en | input | 1 | Engine enable; gates the input source only |
| in_valid | input | 1 | Host offers a word to the input FIFO |
| in_ready | output | 1 | Input FIFO can accept a word |
| in_data | input | 32 | Word from host |
| eng_rd_valid | output | 1 | Input FIFO has a word for the engine |
| eng_rd_ready | input | 1 | Engine takes the head word |
| eng_rd_data | output | 32 | Head word of input FIFO |
| eng_wr_valid | input | 1 | Engine offers a result word |
| eng_wr_ready | output | 1 | Output FIFO can accept a word |
| eng_wr_data | input | 32 | Result word from engine |
| out_valid | output | 1 | Output FIFO has a word for the host |
| out_ready | input | 1 | Host takes the head word |
| out_data | output | 32 | Head word of output FIFO |
| reg_addr | input | 4 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 2 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Combined service interrupt |

## Verification
An occupancy count that drifts inside either FIFO shows at the ports within one cycle. The affected ready or valid flips at the wrong depth, and the raw status bit changes on the wrong side of the four-word or empty boundary. The host's register read shows this at once, and `irq` shows it on the next edge. A corrupted mask shows the same cycle in the mask and masked reads, and one edge later on `irq`. A pointer fault shows as a word out of order on `eng_rd_data` or `out_data` when that word reaches the head.

// File: rtl/svc_irq_pkg.sv
package svc_irq_pkg;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned NUM_SRC  = 2;
  localparam int unsigned SRC_IN   = 0;
  localparam int unsigned SRC_OUT  = 1;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_RAW    = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_MASKED = 4'h8;
  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/svc_word_fifo.sv
module svc_word_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [WIDTH-1:0] wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [WIDTH-1:0] rd_data,
  output logic [LVL_W-1:0] level
);
  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic             push, pop;

  assign wr_ready = (level != LVL_W'(DEPTH));
  assign rd_valid = (level != '0);
  assign push     = wr_valid && wr_ready;
  assign pop      = rd_ready && rd_valid;
  assign rd_data  = store[rptr];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
      if (push && !pop)      level <= level + 1'b1;
      else if (pop && !push) level <= level - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) store[wptr] <= wr_data;
  end

  assert_level_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ready && !rd_ready) |=> level == $past(level));
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_valid && !wr_valid) |=> level == '0);
endmodule

// File: rtl/svc_req_gen.sv
module svc_req_gen
  import svc_irq_pkg::*;
#(
  parameter int unsigned LVL_W     = 4,
  parameter int unsigned IN_THRESH = 4
) (
  input  logic             engine_en,
  input  logic [LVL_W-1:0] in_level,
  input  logic [LVL_W-1:0] out_level,
  output src_vec_t         raw
);
  logic in_low;

  generate
    if (IN_THRESH <= 1) begin : g_empty_cmp
      assign in_low = (in_level == '0);
    end else begin : g_thresh_cmp
      assign in_low = (in_level < LVL_W'(IN_THRESH));
    end
  endgenerate

  always_comb begin
    raw          = '0;
    raw[SRC_IN]  = engine_en && in_low;
    raw[SRC_OUT] = (out_level != '0);
  end
endmodule

// File: rtl/svc_reg_file.sv
module svc_reg_file
  import svc_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  src_vec_t          raw,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  src_vec_t          reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  src_vec_t mask_q;
  src_vec_t masked;

  assign masked = raw & mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      irq    <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == OFS_MASK) mask_q <= reg_wdata;
      irq <= |masked;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_MASK:   reg_rdata[NUM_SRC-1:0] = mask_q;
      OFS_RAW:    reg_rdata[NUM_SRC-1:0] = raw;
      OFS_MASKED: reg_rdata[NUM_SRC-1:0] = masked;
      default:    reg_rdata = '0;
    endcase
  end

  assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == OFS_MASK) |=> $stable(mask_q));
  assert_irq_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == |($past(raw) & $past(mask_q)));
endmodule

// File: rtl/svc_irq_ctrl.sv
module svc_irq_ctrl
  import svc_irq_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned IN_THRESH  = 4,
  localparam int unsigned LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              engine_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              eng_rd_valid,
  input  logic              eng_rd_ready,
  output logic [WORD_W-1:0] eng_rd_data,
  input  logic              eng_wr_valid,
  output logic              eng_wr_ready,
  input  logic [WORD_W-1:0] eng_wr_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  input  logic [3:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [1:0]        reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  logic [LVL_W-1:0] in_lvl, out_lvl;
  src_vec_t         raw;

  svc_word_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(WORD_W)) u_in_fifo (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(in_valid), .wr_ready(in_ready), .wr_data(in_data),
    .rd_valid(eng_rd_valid), .rd_ready(eng_rd_ready), .rd_data(eng_rd_data),
    .level(in_lvl)
  );

  svc_word_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(WORD_W)) u_out_fifo (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(eng_wr_valid), .wr_ready(eng_wr_ready), .wr_data(eng_wr_data),
    .rd_valid(out_valid), .rd_ready(out_ready), .rd_data(out_data),
    .level(out_lvl)
  );

  svc_req_gen #(.LVL_W(LVL_W), .IN_THRESH(IN_THRESH)) u_req (
    .engine_en(engine_en), .in_level(in_lvl), .out_level(out_lvl), .raw(raw)
  );

  svc_reg_file #(.DATA_W(32)) u_regs (
    .clk(clk), .rst_n(rst_n), .raw(raw),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  assert_out_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    raw[SRC_OUT] == out_valid);
  assert_in_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !engine_en |-> !raw[SRC_IN]);
  assert_in_full_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> !raw[SRC_IN]);
endmodule

// File: tb/test_svc_irq_ctrl.sv
module test_svc_irq_ctrl;
  logic clk = 0, rst_n = 0;
  logic engine_en = 0, in_valid = 0, eng_rd_ready = 0, eng_wr_valid = 0, out_ready = 0;
  logic [31:0] in_data = 0, eng_wr_data = 0;
  logic [3:0] reg_addr = 0;
  logic reg_wr = 0;
  logic [1:0] reg_wdata = 0;
  logic in_ready, eng_rd_valid, eng_wr_ready, out_valid, irq;
  logic [31:0] eng_rd_data, out_data, reg_rdata;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] qi [8];
  logic [31:0] qo [8];
  int ih = 0, ic = 0, oh = 0, oc = 0;
  logic [1:0] m_mask = 0;
  logic exp_irq = 0;

  always #10 clk = ~clk;

  svc_irq_ctrl i_svc_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .engine_en(engine_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .eng_rd_valid(eng_rd_valid), .eng_rd_ready(eng_rd_ready), .eng_rd_data(eng_rd_data),
    .eng_wr_valid(eng_wr_valid), .eng_wr_ready(eng_wr_ready), .eng_wr_data(eng_wr_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_raw();
    logic [1:0] r;
    r[0] = engine_en && (ic < 4);
    r[1] = (oc != 0);
    return r;
  endfunction

  // One clock: inputs already set by caller (at negedge); model edge; then check regs.
  task automatic cycle();
    logic [1:0] rp;
    logic pi, po, wi, wo;
    check("R7 in_ready", in_ready, ic < 8);
    check("R7 eng_wr_ready", eng_wr_ready, oc < 8);
    check("R7 eng_rd_valid", eng_rd_valid, ic > 0);
    check("R7 out_valid", out_valid, oc > 0);
    if (ic > 0) check("R8 eng_rd_data", eng_rd_data, qi[ih]);
    if (oc > 0) check("R8 out_data", out_data, qo[oh]);
    rp = exp_raw();
    wi = in_valid && ic < 8;
    pi = eng_rd_ready && ic > 0;
    wo = eng_wr_valid && oc < 8;
    po = out_ready && oc > 0;
    @(posedge clk);
    exp_irq = |(rp & m_mask);
    if (reg_wr && reg_addr == 4'h0) m_mask = reg_wdata;
    if (wi) qi[(ih + ic) % 8] = in_data;
    if (pi) begin ih = (ih + 1) % 8; ic--; end
    if (wi) ic++;
    if (wo) qo[(oh + oc) % 8] = eng_wr_data;
    if (po) begin oh = (oh + 1) % 8; oc--; end
    if (wo) oc++;
    @(negedge clk);
    in_valid = 0; eng_rd_ready = 0; eng_wr_valid = 0; out_ready = 0; reg_wr = 0;
    check("R5 irq", irq, exp_irq);
    reg_addr = 4'h0; #1 check("R6 mask read", reg_rdata, {30'b0, m_mask});
    reg_addr = 4'h4; #1 check("R2/R3 raw read", reg_rdata, {30'b0, exp_raw()});
    check("R2 raw out bit", reg_rdata[1], oc != 0);
    check("R3 raw in bit", reg_rdata[0], engine_en && ic < 4);
    reg_addr = 4'h8; #1 check("R4 masked read", reg_rdata, {30'b0, exp_raw() & m_mask});
    reg_addr = 4'hC; #1 check("R6 unmapped read", reg_rdata, 32'h0);
  endtask

  task automatic push_in(input logic [31:0] d);
    in_valid = 1; in_data = d; cycle();
  endtask

  task automatic write_reg(input logic [3:0] a, input logic [1:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; cycle();
  endtask

  initial begin
    #2000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 irq reset", irq, 0);
    reg_addr = 4'h0; #1 check("R1 mask reset", reg_rdata, 0);
    check("R1 in_ready reset", in_ready, 1);
    check("R1 eng_rd_valid reset", eng_rd_valid, 0);
    check("R1 out_valid reset", out_valid, 0);
    rst_n = 1;
    @(negedge clk);
    // R3: engine disabled, empty input FIFO -> input source low
    cycle();
    check("R3 disabled empty", exp_raw(), 2'b00);
    engine_en = 1;
    write_reg(4'h0, 2'b01);                 // R4 enable input source
    cycle();                                // R5 irq should now be high
    check("R5 irq input high", irq, 1);
    write_reg(4'h4, 2'b11);                 // R6 ignored write to raw
    write_reg(4'h8, 2'b10);                 // R6 ignored write to masked
    write_reg(4'hC, 2'b10);                 // R6 ignored unmapped write
    check("R6 mask kept", m_mask, 2'b01);
    // R3 threshold boundary: 3 words -> high, 4 words -> low
    for (int k = 0; k < 3; k++) push_in(32'hA000_0000 + k);
    check("R3 three words", ic, 3);
    push_in(32'hA000_0003);
    // R7 fill to full, then overflow attempt
    for (int k = 4; k < 10; k++) push_in(32'hA000_0000 + k);
    check("R7 full count", ic, 8);
    // R3 disable keeps input quiet; R2 output source independent of enable
    engine_en = 0;
    eng_wr_valid = 1; eng_wr_data = 32'hBEEF_0001; cycle();
    write_reg(4'h0, 2'b10);
    cycle();
    check("R2 irq output while disabled", irq, 1);
    // R7 drain input with over-reads
    for (int k = 0; k < 10; k++) begin eng_rd_ready = 1; cycle(); end
    out_ready = 1; cycle();
    out_ready = 1; cycle();                 // R7 read from empty ignored
    cycle();
    check("R2 irq drops after drain", irq, 0);
    // Constrained random phases
    engine_en = 1;
    for (int ph = 0; ph < 24; ph++) begin
      int bias = (ph % 3 == 0) ? 80 : (ph % 3 == 1) ? 20 : 50;
      for (int c = 0; c < 100; c++) begin
        in_valid     = ($urandom % 100) < bias;
        in_data      = $urandom;
        eng_rd_ready = ($urandom % 100) < (100 - bias);
        eng_wr_valid = ($urandom % 100) < bias;
        eng_wr_data  = $urandom;
        out_ready    = ($urandom % 100) < (100 - bias);
        if (($urandom % 20) == 0) engine_en = ~engine_en;
        if (($urandom % 15) == 0) begin
          reg_wr = 1; reg_addr = 4'($urandom % 16); reg_wdata = 2'($urandom);
        end
        cycle();
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule